// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor

This block watches the clock and data lines of a two-wire serial bus. It never drives them. Both inputs must already be synchronised to the system clock. Each line passes through its own glitch filter. A filter accepts a new level only after the raw input has held that level for a set number of consecutive system clocks. Pulses shorter than that never reach the condition logic.

The filtered lines feed a condition detector. It reports a bus start, a repeated start and a bus stop, each as a single-cycle pulse. It also keeps a bus-busy flag. Other logic reads that flag to decide whether it may begin a transfer of its own. Whether a start counts as a repeated start depends only on the busy flag.

Top module: `twowire_cond_mon`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `start_pulse`, `rep_start_pulse`, `stop_pulse` and `bus_busy` are all 0. Both filtered lines reset to the high (idle) level.
- R2: A raw level on either line that lasts fewer than `FILT_LEN` consecutive clocks has no effect on any output. A level held for `FILT_LEN` clocks or more is accepted.
- R3: A falling data line while the clock line is high, with the bus idle, gives `start_pulse` = 1 for exactly one cycle. With the raw change first sampled at clock edge 1, the pulse is visible after edge `FILT_LEN`+1.
- R4: A rising data line while the clock line is high gives `stop_pulse` = 1 for one cycle and leaves `bus_busy` at 0. This holds even when the bus was already idle.
- R5: `bus_busy` rises only together with a start pulse. It then stays 1 until a stop pulse.
- R6: A start condition while `bus_busy` is 1 gives `rep_start_pulse` instead of `start_pulse`, and `bus_busy` stays 1.
- R7: A data-line change while the filtered clock line is low raises no pulse.
- R8: At most one of the three pulse outputs is high in any cycle, and no pulse lasts longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronised raw clock line |
| sda_i | input | 1 | Synchronised raw data line |
| start_pulse | output | 1 | One-cycle pulse for a start on an idle bus |
| rep_start_pulse | output | 1 | One-cycle pulse for a start on a busy bus |
| stop_pulse | output | 1 | One-cycle pulse for a stop condition |
| bus_busy | output | 1 | High from a start until the next stop |

## Verification
The bench builds the monitor with `FILT_LEN` = 3. At that setting, spike widths from 1 to `FILT_LEN`+1 can be swept in full on both lines, and the cases just below and at the acceptance threshold each get their own expected outcome.

The clock-line sweep glitches the clock low at the same moment the data line rises. A swallowed glitch must therefore still give a stop, while an accepted one must suppress it. The exact start latency, repeated starts, data changes under a low clock, and a stop on an idle bus are each checked against counts the bench works out itself.

// File: rtl/busmon_pkg.sv
package busmon_pkg;

  // A condition seen on the filtered lines in one cycle.
  typedef struct packed {
    logic fall_hi;  // data fell while clock stayed high
    logic rise_hi;  // data rose while clock stayed high
  } line_cond_t;

  // True when one more disagreeing sample completes the required hold.
  function automatic logic hold_met(input logic [31:0] run_len,
                                    input logic [31:0] need_len);
    return (run_len + 32'd1) >= need_len;
  endfunction

  // Classify a detected start from the busy state: 1 means repeated.
  function automatic logic start_is_repeat(input logic busy_now);
    return busy_now;
  endfunction

endpackage

// File: rtl/busmon_glitch_filter.sv
module busmon_glitch_filter
  import busmon_pkg::*;
#(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);

  localparam int unsigned CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);

  logic [CW-1:0] run_cnt;
  logic          differs;
  logic          accept;

  assign differs = (raw_i != filt_o);
  assign accept  = differs && hold_met(32'(run_cnt), 32'(FILT_LEN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt_o  <= 1'b1;
      run_cnt <= '0;
    end else if (!differs) begin
      run_cnt <= '0;
    end else if (accept) begin
      filt_o  <= raw_i;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + CW'(1);
    end
  end

  // A new filtered level always equals the raw level sampled at that edge.
  assert_filter_follows_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_o != $past(filt_o)) |-> (filt_o == $past(raw_i)));

  // The run counter never reaches the hold length.
  assert_run_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(run_cnt) < FILT_LEN);

endmodule

// File: rtl/busmon_cond_detect.sv
module busmon_cond_detect
  import busmon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_pulse,
  output logic rep_start_pulse,
  output logic stop_pulse,
  output logic bus_busy
);

  logic       scl_q;
  logic       sda_q;
  line_cond_t cond;
  logic       is_rep;

  always_comb begin
    cond.fall_hi = scl_f && scl_q && sda_q && !sda_f;
    cond.rise_hi = scl_f && scl_q && !sda_q && sda_f;
  end

  assign is_rep = start_is_repeat(bus_busy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q           <= 1'b1;
      sda_q           <= 1'b1;
      start_pulse     <= 1'b0;
      rep_start_pulse <= 1'b0;
      stop_pulse      <= 1'b0;
      bus_busy        <= 1'b0;
    end else begin
      scl_q           <= scl_f;
      sda_q           <= sda_f;
      start_pulse     <= cond.fall_hi && !is_rep;
      rep_start_pulse <= cond.fall_hi && is_rep;
      stop_pulse      <= cond.rise_hi;
      if (cond.fall_hi)      bus_busy <= 1'b1;
      else if (cond.rise_hi) bus_busy <= 1'b0;
    end
  end

  assert_pulses_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_pulse, rep_start_pulse, stop_pulse}));

  assert_first_start_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !$past(bus_busy));

  assert_stop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> !bus_busy);

  assert_busy_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse || rep_start_pulse) |-> bus_busy);

  assert_busy_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> start_pulse);

  assert_rep_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rep_start_pulse |-> $past(bus_busy));

endmodule

// File: rtl/twowire_cond_mon.sv
module twowire_cond_mon
  import busmon_pkg::*;
#(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_pulse,
  output logic rep_start_pulse,
  output logic stop_pulse,
  output logic bus_busy
);

  localparam int unsigned NLINES = 2;  // index 0: clock, 1: data

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] filt_lines;
  logic              scl_filt;
  logic              sda_filt;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    busmon_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_lines[g]),
      .filt_o (filt_lines[g])
    );
  end

  assign scl_filt = filt_lines[0];
  assign sda_filt = filt_lines[1];

  busmon_cond_detect u_det (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_f           (scl_filt),
    .sda_f           (sda_filt),
    .start_pulse     (start_pulse),
    .rep_start_pulse (rep_start_pulse),
    .stop_pulse      (stop_pulse),
    .bus_busy        (bus_busy)
  );

  // Any condition needs the filtered clock high one cycle earlier.
  assert_events_need_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse || rep_start_pulse || stop_pulse) |-> $past(scl_filt));

endmodule

// File: tb/twowire_cond_mon_test.sv
module twowire_cond_mon_test;

  localparam int unsigned N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_i = 1'b1;
  logic sda_i = 1'b1;
  logic start_pulse, rep_start_pulse, stop_pulse, bus_busy;

  int n_checks = 0;
  int n_fail   = 0;
  int n_start  = 0;
  int n_rep    = 0;
  int n_stop   = 0;
  int n_wide   = 0;
  int cycles   = 0;
  logic prev_s = 1'b0, prev_r = 1'b0, prev_p = 1'b0;

  always #10 clk = ~clk;

  twowire_cond_mon #(.FILT_LEN(N)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .start_pulse(start_pulse), .rep_start_pulse(rep_start_pulse),
    .stop_pulse(stop_pulse), .bus_busy(bus_busy)
  );

  // Pulse monitor, sampled between edges.
  always @(negedge clk) begin
    if (rst_n) begin
      if (start_pulse) n_start++;
      if (rep_start_pulse) n_rep++;
      if (stop_pulse) n_stop++;
      if ((start_pulse && prev_s) || (rep_start_pulse && prev_r) ||
          (stop_pulse && prev_p) ||
          (int'(start_pulse) + int'(rep_start_pulse) + int'(stop_pulse) > 1))
        n_wide++;
    end
    prev_s = start_pulse; prev_r = rep_start_pulse; prev_p = stop_pulse;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic c, input logic d, input int n);
    scl_i = c; sda_i = d;
    step(n);
  endtask

  task automatic settle();
    step(N + 3);
  endtask

  task automatic clear_counts();
    n_start = 0; n_rep = 0; n_stop = 0;
  endtask

  initial begin
    // R1 reset state
    step(3);
    check(!start_pulse && !rep_start_pulse && !stop_pulse && !bus_busy, "R1 in reset",
          int'({start_pulse, rep_start_pulse, stop_pulse, bus_busy}), 0);
    rst_n = 1'b1;
    step(1);
    check(!bus_busy && !start_pulse, "R1 after release", int'(bus_busy), 0);
    settle();
    check(n_start + n_rep + n_stop == 0, "R1 idle no events", n_start + n_rep + n_stop, 0);

    // R3 exact latency of a first start, R5 busy set
    sda_i = 1'b0;
    for (int k = 1; k <= int'(N); k++) begin
      step(1);
      check(!start_pulse, "R3 no early pulse", int'(start_pulse), 0);
    end
    step(1);
    check(start_pulse == 1'b1, "R3 pulse at FILT_LEN+1", int'(start_pulse), 1);
    check(bus_busy == 1'b1, "R5 busy with start", int'(bus_busy), 1);
    step(1);
    check(!start_pulse, "R8 pulse one cycle", int'(start_pulse), 0);

    // R7 data change while clock low, then R6 repeated start
    clear_counts();
    drive(1'b0, 1'b0, N + 3);
    drive(1'b0, 1'b1, N + 3);
    check(n_start + n_rep + n_stop == 0, "R7 data under low clock", n_start + n_rep + n_stop, 0);
    drive(1'b1, 1'b1, N + 3);
    drive(1'b1, 1'b0, N + 3);
    check(n_rep == 1, "R6 repeated start count", n_rep, 1);
    check(n_start == 0, "R6 no first-start pulse", n_start, 0);
    check(bus_busy == 1'b1, "R6 busy stays", int'(bus_busy), 1);

    // R4 stop clears busy
    clear_counts();
    drive(1'b1, 1'b1, N + 3);
    check(n_stop == 1, "R4 stop count", n_stop, 1);
    check(!bus_busy, "R4 busy cleared", int'(bus_busy), 0);

    // R2 data spike sweep on idle bus
    for (int w = 1; w <= int'(N) + 1; w++) begin
      clear_counts();
      drive(1'b1, 1'b0, w);
      drive(1'b1, 1'b1, N + 3);
      check(n_start == ((w >= int'(N)) ? 1 : 0), $sformatf("R2 data spike w=%0d start", w),
            n_start, (w >= int'(N)) ? 1 : 0);
      check(n_stop == ((w >= int'(N)) ? 1 : 0), $sformatf("R2 data spike w=%0d stop", w),
            n_stop, (w >= int'(N)) ? 1 : 0);
      check(!bus_busy, "R5 busy idle after spike", int'(bus_busy), 0);
    end

    // R2 clock glitch sweep: clock dips low as data rises
    for (int w = 1; w <= int'(N) + 1; w++) begin
      drive(1'b1, 1'b0, N + 3);   // start
      drive(1'b0, 1'b0, N + 3);
      drive(1'b1, 1'b0, N + 3);
      clear_counts();
      drive(1'b0, 1'b1, w);
      drive(1'b1, 1'b1, N + 3);
      check(n_stop == ((w < int'(N)) ? 1 : 0), $sformatf("R2 clock glitch w=%0d stop", w),
            n_stop, (w < int'(N)) ? 1 : 0);
      check(bus_busy == (w >= int'(N)), $sformatf("R7 busy after glitch w=%0d", w),
            int'(bus_busy), (w >= int'(N)) ? 1 : 0);
      if (w >= int'(N)) begin
        drive(1'b0, 1'b1, N + 3);
        drive(1'b0, 1'b0, N + 3);
        drive(1'b1, 1'b0, N + 3);
        drive(1'b1, 1'b1, N + 3);
        check(!bus_busy, "R4 cleanup stop", int'(bus_busy), 0);
      end
    end

    // R7 toggles under low clock while busy
    drive(1'b1, 1'b0, N + 3);
    clear_counts();
    drive(1'b0, 1'b0, N + 3);
    for (int t = 0; t < 4; t++) drive(1'b0, 1'(t % 2 == 0), N + 3);
    check(n_start + n_rep + n_stop == 0, "R7 toggles while busy", n_start + n_rep + n_stop, 0);
    check(bus_busy == 1'b1, "R5 busy held", int'(bus_busy), 1);
    drive(1'b0, 1'b0, N + 3);
    drive(1'b1, 1'b0, N + 3);
    drive(1'b1, 1'b1, N + 3);

    // R4 stop on idle bus
    clear_counts();
    drive(1'b0, 1'b1, N + 3);
    drive(1'b0, 1'b0, N + 3);
    drive(1'b1, 1'b0, N + 3);
    check(n_start == 0 && !bus_busy, "R7 no start from low clock", n_start, 0);
    drive(1'b1, 1'b1, N + 3);
    check(n_stop == 1, "R4 idle stop pulse", n_stop, 1);
    check(!bus_busy, "R4 idle stays idle", int'(bus_busy), 0);

    check(n_wide == 0, "R8 pulse width and exclusivity", n_wide, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule